// File: doc/BRIEF.md
# Lock-Gated Configuration and Signature Access Controller

This block sits between a device programmer interface and the stores it reaches. It holds a small configuration byte store, a preload register that drives state into the device's registers, and an eight-byte user signature area. Each command arrives as one transfer on a valid/ready command channel. Each accepted command produces exactly one response beat on a valid/ready response channel. A response beat carries either read data or a refusal flag.

A single sticky security bit decides which commands are allowed. Once it is set, reads of the configuration store, writes to it and preloads of the register are all refused. The signature area stays readable and writable at all times. The bit takes effect at once, so the command accepted right after the lock command already sees it. Only a full erase clears the bit, and the erase also wipes the configuration store.

Back-pressure works as follows. The block holds one response at a time. A new command is accepted only when no response is pending, or when the pending one is being taken in the same cycle.

Top module: `lockgate_ctrl`

## Requirements
- R1: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever no response is pending, and whenever a pending response is being taken that cycle. The response for a command appears in the cycle after it is accepted, and each command produces exactly one response.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_deny` hold their values.
- R3: After reset the following values hold: `rsp_valid`=0, `cmd_ready`=1, `secured`=0 and `preload_q`=0. Every configuration byte and every signature byte reads back as 0.
- R4: While the block is unlocked, op 1 (config write) stores `cmd_wdata` at `cmd_addr`. Op 0 (config read) returns the byte stored at `cmd_addr` with `rsp_deny`=0.
- R5: Op 5 (secure) sets the lock. `secured` is high from the edge that accepts the command onward, and the next accepted command is already gated by the lock. The response to op 5 has `rsp_deny`=0 and data 0.
- R6: While the block is locked, op 0 (config read) is refused.
- R7: While the block is locked, op 2 (preload) and op 1 (config write) are refused and change no state: `preload_q` and the configuration store keep their values.
- R8: Op 3 (signature read) returns signature byte `cmd_addr[2:0]`. Op 4 (signature write) stores `cmd_wdata` there. Neither op is ever refused, whatever the lock state.
- R9: The lock is sticky. Only op 6 (erase) clears it. The erase also sets every configuration byte to 0 and leaves the signature and `preload_q` unchanged.
- R10: A refused command gives one response beat with `rsp_deny`=1 and `rsp_data`=0. Op 7 is reserved and is always refused.
- R11: While the block is unlocked, op 2 (preload) loads `cmd_wdata` into `preload_q`. Its response has `rsp_deny`=0 and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command transfer valid |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Operation code (0 config read to 7 reserved) |
| cmd_addr | input | 4 | Config byte address; low 3 bits select the signature byte |
| cmd_wdata | input | 8 | Write or preload data |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read data, zero for non-read or refused commands |
| rsp_deny | output | 1 | Command was refused |
| secured | output | 1 | Lock state |
| preload_q | output | 8 | Preload register contents |

## Verification
The hardest case to reach is a lock command followed straight away by a gated command. That second command must be checked against the new lock state, with no idle cycle between the two. The bench gets there by issuing the secure command and a config read back to back while the response channel is kept ready. A second run with random response stalls covers refused beats that wait under back-pressure. The bench also checks that the signature and the preload register come through the lock-and-erase sequence with the values required of them.

// File: rtl/lockgate_pkg.sv
package lockgate_pkg;
  typedef enum logic [2:0] {
    OP_CFG_RD  = 3'd0,
    OP_CFG_WR  = 3'd1,
    OP_PRELOAD = 3'd2,
    OP_SIG_RD  = 3'd3,
    OP_SIG_WR  = 3'd4,
    OP_SECURE  = 3'd5,
    OP_ERASE   = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  typedef struct packed {
    logic deny;
    logic cfg_we;
    logic pre_we;
    logic sig_we;
    logic lock_set;
    logic lock_clr;
    logic sel_cfg;
    logic sel_sig;
  } gate_t;
endpackage

// File: rtl/lockgate_lock.sv
module lockgate_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic lock_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      lock_o <= 1'b0;
    else if (clr_i)  lock_o <= 1'b0;
    else if (set_i)  lock_o <= 1'b1;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o && !clr_i |=> lock_o); // R9
  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !clr_i |=> lock_o); // R5
endmodule

// File: rtl/lockgate_gate.sv
module lockgate_gate
  import lockgate_pkg::*;
(
  input  logic  fire_i,
  input  logic  [2:0] op_i,
  input  logic  locked_i,
  output gate_t g_o
);
  op_e op;
  always_comb begin
    op = op_e'(op_i);
    g_o = '0;
    unique case (op)
      OP_CFG_RD:  begin g_o.deny = locked_i; g_o.sel_cfg = !locked_i; end
      OP_CFG_WR:  begin g_o.deny = locked_i; g_o.cfg_we = fire_i && !locked_i; end
      OP_PRELOAD: begin g_o.deny = locked_i; g_o.pre_we = fire_i && !locked_i; end
      OP_SIG_RD:  g_o.sel_sig = 1'b1;
      OP_SIG_WR:  g_o.sig_we = fire_i;
      OP_SECURE:  g_o.lock_set = fire_i;
      OP_ERASE:   g_o.lock_clr = fire_i;
      default:    g_o.deny = 1'b1;
    endcase
  end
endmodule

// File: rtl/lockgate_cfg_store.sv
module lockgate_cfg_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          erase,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n || erase)                       mem[i] <= '0;
      else if (we && addr == AW'(i))             mem[i] <= wdata;
    end
  end

  assign rdata = mem[addr];

  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> rdata == '0); // R9
endmodule

// File: rtl/lockgate_sig_bank.sv
module lockgate_sig_bank #(
  parameter int BYTES = 8,
  parameter int W     = 8,
  localparam int AW   = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] sig [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                      sig[b] <= '0;
      else if (we && addr == AW'(b))   sig[b] <= wdata;
    end
  end

  assign rdata = sig[addr];
endmodule

// File: rtl/lockgate_ctrl.sv
module lockgate_ctrl
  import lockgate_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CFG_DEPTH = 16,
  parameter int SIG_BYTES = 8,
  localparam int CFG_AW   = $clog2(CFG_DEPTH),
  localparam int SIG_AW   = $clog2(SIG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [CFG_AW-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_deny,
  output logic              secured,
  output logic [DATA_W-1:0] preload_q
);
  logic              fire;
  gate_t             g;
  logic [DATA_W-1:0] cfg_rdata, sig_rdata, rd_mux;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;

  lockgate_gate u_gate (
    .fire_i(fire), .op_i(cmd_op), .locked_i(secured), .g_o(g)
  );

  lockgate_lock u_lock (
    .clk(clk), .rst_n(rst_n), .set_i(g.lock_set), .clr_i(g.lock_clr), .lock_o(secured)
  );

  lockgate_cfg_store #(.DEPTH(CFG_DEPTH), .W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(g.cfg_we), .erase(g.lock_clr),
    .addr(cmd_addr), .wdata(cmd_wdata), .rdata(cfg_rdata)
  );

  lockgate_sig_bank #(.BYTES(SIG_BYTES), .W(DATA_W)) u_sig (
    .clk(clk), .rst_n(rst_n), .we(g.sig_we), .addr(cmd_addr[SIG_AW-1:0]),
    .wdata(cmd_wdata), .rdata(sig_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        preload_q <= '0;
    else if (g.pre_we) preload_q <= cmd_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (g.sel_cfg) rd_mux = cfg_rdata;
    if (g.sel_sig) rd_mux = sig_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_deny  <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= g.deny ? '0 : rd_mux;
      rsp_deny  <= g.deny;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> cmd_ready); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_deny)); // R2
  AST_DENY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_deny |-> rsp_data == '0); // R10
  AST_PRELOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    fire && secured && cmd_op == OP_PRELOAD |=> $stable(preload_q)); // R7
  AST_SIG_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (cmd_op == OP_SIG_RD || cmd_op == OP_SIG_WR) |=> rsp_valid && !rsp_deny); // R8
  AST_CFG_RD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    fire && secured && cmd_op == OP_CFG_RD |=> rsp_deny); // R6
endmodule

// File: tb/sim_lockgate_ctrl.sv
module sim_lockgate_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [3:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       rsp_deny;
  logic       secured;
  logic [7:0] preload_q;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  lockgate_ctrl u0 (.*);

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic       m_lock = 1'b0;
  logic [7:0] m_cfg [16];
  logic [7:0] m_sig [8];
  logic [7:0] m_pre = '0;

  logic       bp_en = 1'b0;
  logic [7:0] lfsr  = 8'h5b;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = bp_en ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic       held = 1'b0;
  logic [8:0] held_v;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held && rsp_valid)
        chk({rsp_deny, rsp_data} == held_v, "R2 hold", {rsp_deny, rsp_data}, held_v);
      held = 1'b0;
      if (rsp_valid && !rsp_ready) begin
        held = 1'b1;
        held_v = {rsp_deny, rsp_data};
      end else if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 extra response", {rsp_deny, rsp_data}, 0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({rsp_deny, rsp_data} == e, t, {rsp_deny, rsp_data}, e);
        end
      end
    end
  end

  task automatic send(input logic [2:0] op, input logic [3:0] a,
                      input logic [7:0] d, input string tag);
    logic [8:0] e;
    e = '0;
    case (op)
      3'd0: if (m_lock) e = 9'h100; else e = {1'b0, m_cfg[a]};
      3'd1: if (m_lock) e = 9'h100; else m_cfg[a] = d;
      3'd2: if (m_lock) e = 9'h100; else m_pre = d;
      3'd3: e = {1'b0, m_sig[a[2:0]]};
      3'd4: m_sig[a[2:0]] = d;
      3'd5: m_lock = 1'b1;
      3'd6: begin m_lock = 1'b0; for (int i = 0; i < 16; i++) m_cfg[i] = '0; end
      default: e = 9'h100;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0 || rsp_valid);
    @(negedge clk);
  endtask

  task automatic run();
    for (int i = 0; i < 16; i++) m_cfg[i] = '0;
    for (int i = 0; i < 8; i++)  m_sig[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R3 rsp_valid", rsp_valid, 0);
    chk(cmd_ready == 1'b1, "R3 cmd_ready", cmd_ready, 1);
    chk(secured == 1'b0,   "R3 secured", secured, 0);
    chk(preload_q == 8'h0, "R3 preload_q", preload_q, 0);
    send(3'd0, 4'd9, 8'h0, "R3 cfg reset value");
    send(3'd3, 4'd6, 8'h0, "R3 sig reset value");

    for (int i = 0; i < 8; i++) send(3'd4, 4'(i), 8'(8'h11 * i + 3), "R8 sig write");
    for (int i = 0; i < 8; i++) send(3'd3, 4'(i), 8'h0, "R8 sig read");
    for (int i = 0; i < 16; i++) send(3'd1, 4'(i), 8'(8'hc3 ^ (i * 7)), "R4 cfg write");
    for (int i = 15; i >= 0; i--) send(3'd0, 4'(i), 8'h0, "R4 cfg read");
    send(3'd2, 4'd0, 8'ha5, "R11 preload ack");
    drain();
    chk(preload_q == m_pre, "R11 preload_q", preload_q, m_pre);
    send(3'd7, 4'd2, 8'hff, "R10 reserved op denied");

    bp_en = 1'b1;
    for (int i = 0; i < 12; i++) send(3'(i % 2 == 0 ? 0 : 3), 4'(i), 8'h0, "R2 read under stall");
    drain();
    bp_en = 1'b0;

    send(3'd5, 4'd0, 8'h0, "R5 secure ack");
    chk(secured == 1'b1, "R5 secured immediate", secured, 1);
    send(3'd0, 4'd3, 8'h0, "R6 cfg read right after secure");
    send(3'd2, 4'd0, 8'h3c, "R7 preload denied");
    send(3'd1, 4'd3, 8'h77, "R7 cfg write denied");
    drain();
    chk(preload_q == 8'ha5, "R7 preload_q kept", preload_q, 8'ha5);
    bp_en = 1'b1;
    send(3'd0, 4'd1, 8'h0, "R10 denied under stall");
    send(3'd4, 4'd5, 8'h9e, "R8 sig write locked");
    send(3'd3, 4'd5, 8'h0, "R8 sig read locked");
    send(3'd3, 4'd2, 8'h0, "R8 sig read locked");
    drain();
    bp_en = 1'b0;
    send(3'd5, 4'd0, 8'h0, "R9 secure again");
    drain();
    chk(secured == 1'b1, "R9 lock sticky", secured, 1);

    send(3'd6, 4'd0, 8'h0, "R9 erase ack");
    drain();
    chk(secured == 1'b0, "R9 erase unlocks", secured, 0);
    chk(preload_q == 8'ha5, "R9 preload_q kept by erase", preload_q, 8'ha5);
    send(3'd0, 4'd3, 8'h0, "R9 cfg cleared");
    send(3'd0, 4'd15, 8'h0, "R9 cfg cleared");
    send(3'd3, 4'd5, 8'h0, "R9 sig kept");
    send(3'd2, 4'd0, 8'h42, "R11 preload after erase");
    drain();
    chk(preload_q == 8'h42, "R11 preload_q after erase", preload_q, 8'h42);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule